// File: doc/BRIEF.md
# Integrity Status and Interrupt Controller

This block gathers the events of a per-frame display integrity checker into a set of sticky status flags and turns them into two interrupt lines. One flag records that a frame's comparison results are available. A bank of per-region flags records which regions of interest produced a signature mismatch. An error indication is formed as the OR of all region flags and cannot be cleared by itself. It falls only once every region flag has been cleared.

Software reaches the block through a simple register port. The status register is cleared by writing ones. The control register holds two interrupt mask bits and a freeze bit. A set mask bit disables its interrupt, and both masks come out of reset set. Once the freeze bit is set, the masks can no longer be changed until reset. The freeze behaviour is a two-state machine: `CTL_OPEN`, where mask writes are accepted, and `CTL_FROZEN`, where they are ignored. The only transition, `OPEN->FROZEN`, is taken on a control write with the freeze bit at 1. There is no transition back except reset.

Top module: `isc_status_irq`

## Requirements
- R1: After reset, all status flags read 0, both mask bits read 1, the freeze bit reads 0, and both interrupt outputs are low.
- R2: A one-cycle pulse on `frame_done` sets the ready flag, status bit 0, at the next clock edge, and the flag stays set until cleared.
- R3: A pulse on `region_miss[i]` sets region flag i, status bit 2+i, at the next clock edge, and the flag stays set until cleared.
- R4: Status bit 1 (error) reads as the OR of all region flags. Writing 1 to bit 1 has no effect on it.
- R5: A write to the status address (0) clears every flag whose bit in `wr_data` is 1 (bit 0 for ready, bit 2+i for region i) and leaves the others unchanged.
- R6: When a set event and a clear of the same flag happen in one cycle, the flag ends up set.
- R7: Control register (address 1) bit 0 masks the functional interrupt and bit 1 masks the error interrupt. `irq_func` equals ready AND NOT bit 0, and `irq_err` equals error AND NOT bit 1.
- R8: Writing the control register with bit 2 (freeze) at 1 stores that write's mask bits and freezes them. After that, control writes change neither the masks nor the freeze bit until reset.
- R9: Writes to addresses 2 and 3 change no state, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | Pulse: a frame's comparison results are ready |
| region_miss | input | NUM_REGIONS | Per-region mismatch pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| irq_func | output | 1 | Functional interrupt, active high |
| irq_err | output | 1 | Error interrupt, active high |

## Verification
The bench builds the block with the defaults: sixteen regions and a 32-bit data path. This places the highest region flag at bit 17, so the full width of the flag bank is reached. The tests drive regions 0, 2 and 3 and check the error OR as individual flags are cleared one by one. They include same-cycle set and clear races on both a region flag and the ready flag. The freeze tests check that masks stay fixed after the freeze bit is set, and that a second reset releases them.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int ADDR_STATUS  = 0;
    localparam int ADDR_CONTROL = 1;

    localparam int ST_READY_BIT = 0;
    localparam int ST_ERR_BIT   = 1;
    localparam int ST_REGION_LO = 2;

    localparam int CT_MASK_FUNC = 0;
    localparam int CT_MASK_ERR  = 1;
    localparam int CT_FREEZE    = 2;

    typedef enum logic {
        CTL_OPEN   = 1'b0,
        CTL_FROZEN = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/isc_flag_bank.sv
module isc_flag_bank #(
    parameter int WIDTH = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] flag_q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else if (set_vec[i])
                flag_q[i] <= 1'b1;
            else if (clr_vec[i])
                flag_q[i] <= 1'b0;
        end

        // R6: set wins over clear
        a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flag_q[i]);
        // R5: clear without set drops the flag
        a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !flag_q[i]);
        // R2 / R3: sticky until cleared
        a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr_vec[i]) |=> flag_q[i]);
    end
endmodule

// File: rtl/isc_ctl_fsm.sv
module isc_ctl_fsm
    import isc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic wr_mask_func,
    input  logic wr_mask_err,
    input  logic wr_freeze,
    output logic mask_func,
    output logic mask_err,
    output logic frozen
);
    ctl_state_t state_q, state_d;
    logic [1:0] mask_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_OPEN:   if (ctl_wr && wr_freeze) state_d = CTL_FROZEN;
            CTL_FROZEN: state_d = CTL_FROZEN;
            default:    state_d = CTL_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_OPEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= 2'b11;
        else if (ctl_wr && state_q == CTL_OPEN)
            mask_q <= {wr_mask_err, wr_mask_func};
    end

    always_comb begin
        mask_func = mask_q[0];
        mask_err  = mask_q[1];
        frozen    = (state_q == CTL_FROZEN);
    end

    // R8: frozen masks never move
    a_r8_masks_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTL_FROZEN) |=> $stable(mask_q));
    // R8: freeze is sticky
    a_r8_freeze_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTL_FROZEN) |=> (state_q == CTL_FROZEN));
endmodule

// File: rtl/isc_status_irq.sv
module isc_status_irq
    import isc_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_done,
    input  logic [NUM_REGIONS-1:0] region_miss,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   irq_func,
    output logic                   irq_err
);
    localparam int FLAGS = NUM_REGIONS + 1;

    logic [FLAGS-1:0]       set_vec, clr_vec, flag_q;
    logic [NUM_REGIONS-1:0] region_q;
    logic                   ready_q, err_s;
    logic                   st_wr, ctl_wr;
    logic                   mask_func, mask_err, frozen;
    logic                   unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    assign st_wr  = wr_en && (wr_addr == ADDR_W'(ADDR_STATUS));
    assign ctl_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CONTROL));

    assign set_vec = {region_miss, frame_done};
    assign clr_vec = st_wr ? {wr_data[ST_REGION_LO +: NUM_REGIONS], wr_data[ST_READY_BIT]}
                           : '0;

    isc_flag_bank #(.WIDTH(FLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flag_q  (flag_q)
    );

    isc_ctl_fsm u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (ctl_wr),
        .wr_mask_func (wr_data[CT_MASK_FUNC]),
        .wr_mask_err  (wr_data[CT_MASK_ERR]),
        .wr_freeze    (wr_data[CT_FREEZE]),
        .mask_func    (mask_func),
        .mask_err     (mask_err),
        .frozen       (frozen)
    );

    assign ready_q  = flag_q[0];
    assign region_q = flag_q[FLAGS-1:1];
    assign err_s    = |region_q;

    assign irq_func = ready_q & ~mask_func;
    assign irq_err  = err_s & ~mask_err;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_STATUS)) begin
            rd_data[ST_READY_BIT]                 = ready_q;
            rd_data[ST_ERR_BIT]                   = err_s;
            rd_data[ST_REGION_LO +: NUM_REGIONS]  = region_q;
        end else if (rd_addr == ADDR_W'(ADDR_CONTROL)) begin
            rd_data[CT_MASK_FUNC] = mask_func;
            rd_data[CT_MASK_ERR]  = mask_err;
            rd_data[CT_FREEZE]    = frozen;
        end
    end

    // R7: masked interrupts stay low
    a_r7_func_masked: assert property (@(posedge clk) disable iff (!rst_n)
        mask_func |-> !irq_func);
    a_r7_err_masked: assert property (@(posedge clk) disable iff (!rst_n)
        mask_err |-> !irq_err);
    // R4: no error interrupt without a region flag
    a_r4_err_needs_region: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[FLAGS-1:1] == '0) |-> !irq_err);
    // R2: a frame event raises readiness next cycle
    a_r2_ready_rises: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> ready_q);
endmodule

// File: tb/isc_status_irq_test.sv
module isc_status_irq_test;
    localparam int NR = 16;
    localparam int DW = 32;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_done = 1'b0;
    logic [NR-1:0] region_miss = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          irq_func, irq_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    isc_status_irq #(.NUM_REGIONS(NR), .DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .region_miss(region_miss),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_func(irq_func), .irq_err(irq_err)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic f, input logic [NR-1:0] r);
        @(negedge clk);
        frame_done = f; region_miss = r;
        @(negedge clk);
        frame_done = 1'b0; region_miss = '0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [DW-1:0] v;
        do_reset();
        rd(0, v); check("R1 status", v, 32'h0);
        rd(1, v); check("R1 control", v, 32'h3);
        check("R1 irqs", {30'b0, irq_func, irq_err}, 32'h0);
    endtask

    task automatic t_frame;
        logic [DW-1:0] v;
        pulse(1'b1, '0);
        rd(0, v); check("R2 ready set", v, 32'h1);
        check("R7 func masked", {31'b0, irq_func}, 32'h0);
        repeat (3) @(negedge clk);
        rd(0, v); check("R2 sticky", v, 32'h1);
        wr(1, 32'h0);
        check("R7 func unmasked", {31'b0, irq_func}, 32'h1);
    endtask

    task automatic t_region;
        logic [DW-1:0] v;
        pulse(1'b0, 16'h0005);
        rd(0, v); check("R3 regions 0,2 + R4 err", v, 32'h17);
        check("R7 err irq", {31'b0, irq_err}, 32'h1);
        pulse(1'b0, 16'h8000);
        rd(0, v); check("R3 region 15 at bit 17", v, 32'h20017);
        wr(0, 32'h20000);
        rd(0, v); check("R5 clear region 15", v, 32'h17);
    endtask

    task automatic t_clear;
        logic [DW-1:0] v;
        wr(0, 32'h2);
        rd(0, v); check("R4 err not clearable", v, 32'h17);
        wr(0, 32'h4);
        rd(0, v); check("R5 clear region 0, R4 err held", v, 32'h13);
        check("R4 irq_err held", {31'b0, irq_err}, 32'h1);
        wr(0, 32'h10);
        rd(0, v); check("R4 err drops", v, 32'h1);
        check("R4 irq_err low", {31'b0, irq_err}, 32'h0);
        wr(0, 32'h1);
        rd(0, v); check("R5 clear ready", v, 32'h0);
        check("R7 irq_func low", {31'b0, irq_func}, 32'h0);
    endtask

    task automatic t_race;
        logic [DW-1:0] v;
        @(negedge clk);
        region_miss = 16'h0008; frame_done = 1'b1;
        wr_en = 1'b1; wr_addr = 0; wr_data = 32'h21;
        @(negedge clk);
        region_miss = '0; frame_done = 1'b0; wr_en = 1'b0; wr_data = '0;
        rd(0, v); check("R6 set beats clear", v, 32'h23);
        wr(0, 32'hFFFF_FFFF);
        rd(0, v); check("R5 clear all", v, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [DW-1:0] v;
        pulse(1'b1, 16'h0002);
        wr(2, 32'hFFFF_FFFF);
        wr(3, 32'hFFFF_FFFF);
        rd(0, v); check("R9 status untouched", v, 32'hB);
        rd(1, v); check("R9 control untouched", v, 32'h0);
        rd(2, v); check("R9 read 2 zero", v, 32'h0);
        rd(3, v); check("R9 read 3 zero", v, 32'h0);
        wr(0, 32'hFFFF_FFFF);
    endtask

    task automatic t_freeze;
        logic [DW-1:0] v;
        wr(1, 32'h5);
        rd(1, v); check("R8 freeze write", v, 32'h5);
        wr(1, 32'h0);
        rd(1, v); check("R8 masks and freeze locked", v, 32'h5);
        wr(1, 32'h2);
        rd(1, v); check("R8 still locked", v, 32'h5);
        pulse(1'b1, 16'h0001);
        check("R8 func stays masked", {31'b0, irq_func}, 32'h0);
        check("R8 err unmasked", {31'b0, irq_err}, 32'h1);
        do_reset();
        rd(1, v); check("R1 reset releases freeze", v, 32'h3);
        wr(1, 32'h0);
        rd(1, v); check("R8 writable after reset", v, 32'h0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_frame();
                t_region();
                t_clear();
                t_race();
                t_unmapped();
                t_freeze();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule